// File: doc/BRIEF.md
# Sector Erase Window Timer

This block sequences a multi-sector erase in a flash command controller. When a valid sector erase command arrives while nothing else is in progress, the block opens an accept window. While the window is open, every further sector erase command adds its sector to an erase mask and restarts the window. If no new sector command arrives for `WINDOW_TICKS` ticks of the microsecond prescaler, the window closes. The block then pulses `erase_start` to the erase executor, which works through the mask and answers with `erase_done`.

The command decoder upstream sends one-cycle strobes: sector erase with a sector index, suspend, resume, and "any other command". A suspend during a running erase raises `exec_hold` at once, so the executor pauses. The `suspended` flag rises only after the `SUSPEND_TICKS` latency has elapsed. A suspend during the window skips the wait and suspends immediately. In that case the erase itself is launched by the later resume. The `window_closed` output is the polled window status bit. All pins are plain control and status signals. The block has no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `sector_erase_ctl`

## Requirements
- R1: After reset, `erase_mask` is 0 and `erase_active`, `suspended`, `window_closed`, `erase_start` and `exec_hold` are all 0.
- R2: A sector command with an index below `NUM_SECTORS`, received in idle, opens the window. The mask becomes the single bit at that index (bit i = sector i). `window_closed` stays 0 while the window is open.
- R3: Inside the window, each further valid sector command ORs its bit into the mask and restarts the window count. This holds even when the command lands in the same cycle as the tick that would have expired the window.
- R4: When `WINDOW_TICKS` ticks pass with no new sector command, the block does three things one cycle after the last tick: it pulses `erase_start` for exactly one cycle, raises `erase_active` and sets `window_closed` to 1.
- R5: A non-sector, non-suspend command inside the window clears the mask and returns to idle without starting an erase.
- R6: Once the erase has begun, sector, other and resume commands are ignored, and the mask holds its value until `erase_done`.
- R7: A suspend during a running erase raises `exec_hold` on the next cycle. `suspended` rises and `erase_active` falls after `SUSPEND_TICKS` further ticks. Repeated suspends are ignored.
- R8: A suspend inside the window ends it at once and gives the following state on the next cycle: `suspended` = 1, `window_closed` = 1, no `erase_start`. The first resume then issues `erase_start`.
- R9: While suspended, only resume has an effect: it returns to the running erase with `exec_hold` low. Extra resumes are ignored, and a later suspend is accepted again.
- R10: `erase_done` during a running or suspend-pending erase clears the mask and returns to idle. It is ignored while idle, in the window, or while suspended.
- R11: Sector indices of `NUM_SECTORS` or more are ignored. Suspend and resume while idle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per prescaler period |
| cmd_sector | input | 1 | Sector erase command strobe |
| cmd_sector_idx | input | SEC_W | Sector index of the sector command |
| cmd_suspend | input | 1 | Suspend command strobe |
| cmd_resume | input | 1 | Resume command strobe |
| cmd_other | input | 1 | Any other command strobe |
| erase_done | input | 1 | Executor finished the erase |
| erase_mask | output | NUM_SECTORS | Queued sectors, bit i = sector i |
| erase_start | output | 1 | One-cycle launch pulse to the executor |
| erase_active | output | 1 | Erase running or suspend pending |
| exec_hold | output | 1 | Executor must pause |
| suspended | output | 1 | Erase suspended, reads allowed |
| window_closed | output | 1 | Window status: 0 while accepting sectors, 1 once erase has begun |

## Verification
Every cycle, the assertions check the following:
- the launch pulse lasts a single cycle, and the window reads closed from that pulse onward;
- the mask stays frozen for as long as the window is closed;
- the suspended state always carries a non-empty mask;
- the timers stay within their limits.

Other behaviours can only be shown by the bench's scenarios:
- the exact tick on which the window expires, and the restart when a sector command coincides with the expiring tick;
- a discard caused by another command;
- the suspend latency, and the resume that launches an erase suspended inside the window;
- the commands that must be ignored.

// File: rtl/sew_pkg.sv
package sew_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WINDOW = 3'd1,
    ST_ERASE  = 3'd2,
    ST_SWAIT  = 3'd3,
    ST_SUSP   = 3'd4
  } sew_state_e;
endpackage

// File: rtl/sew_tick_timer.sv
module sew_tick_timer #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic tick,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  assign expire = run && tick && !restart && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (!run || restart) cnt <= '0;
    else if (tick)            cnt <= cnt + 1'b1;
  end

  // R3/R4: the count never passes its limit
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT));
endmodule

// File: rtl/sew_mask_acc.sv
module sew_mask_acc #(
  parameter int NUM_SECTORS = 11,
  parameter int SEC_W = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   add,
  input  logic [SEC_W-1:0]       idx,
  output logic [NUM_SECTORS-1:0] mask
);
  logic [NUM_SECTORS-1:0] onehot;

  for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_dec
    assign onehot[g] = (idx == SEC_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) mask <= '0;
    else if (add)      mask <= mask | onehot;
  end
endmodule

// File: rtl/sector_erase_ctl.sv
module sector_erase_ctl #(
  parameter int NUM_SECTORS   = 11,
  parameter int WINDOW_TICKS  = 100,
  parameter int SUSPEND_TICKS = 15,
  parameter int SEC_W         = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   cmd_sector,
  input  logic [SEC_W-1:0]       cmd_sector_idx,
  input  logic                   cmd_suspend,
  input  logic                   cmd_resume,
  input  logic                   cmd_other,
  input  logic                   erase_done,
  output logic [NUM_SECTORS-1:0] erase_mask,
  output logic                   erase_start,
  output logic                   erase_active,
  output logic                   exec_hold,
  output logic                   suspended,
  output logic                   window_closed
);
  import sew_pkg::*;

  sew_state_e state, nxt;
  logic       launched;
  logic       sector_ok, win_expire, susp_expire;
  logic       start_d, mask_add, mask_clr;

  assign sector_ok = cmd_sector && (cmd_sector_idx < SEC_W'(NUM_SECTORS));

  sew_tick_timer #(.LIMIT(WINDOW_TICKS)) u_win_timer (
    .clk(clk), .rst_n(rst_n),
    .run(state == ST_WINDOW),
    .restart((state == ST_WINDOW) && sector_ok),
    .tick(tick), .expire(win_expire)
  );

  sew_tick_timer #(.LIMIT(SUSPEND_TICKS)) u_susp_timer (
    .clk(clk), .rst_n(rst_n),
    .run(state == ST_SWAIT),
    .restart(1'b0),
    .tick(tick), .expire(susp_expire)
  );

  always_comb begin
    nxt      = state;
    start_d  = 1'b0;
    mask_add = 1'b0;
    unique case (state)
      ST_IDLE: if (sector_ok) begin
        nxt = ST_WINDOW; mask_add = 1'b1;
      end
      ST_WINDOW: begin
        if (cmd_other)        nxt = ST_IDLE;
        else if (cmd_suspend) nxt = ST_SUSP;
        else if (sector_ok)   mask_add = 1'b1;
        else if (win_expire) begin
          nxt = ST_ERASE; start_d = 1'b1;
        end
      end
      ST_ERASE: begin
        if (erase_done)       nxt = ST_IDLE;
        else if (cmd_suspend) nxt = ST_SWAIT;
      end
      ST_SWAIT: begin
        if (erase_done)       nxt = ST_IDLE;
        else if (susp_expire) nxt = ST_SUSP;
      end
      ST_SUSP: if (cmd_resume) begin
        nxt = ST_ERASE; start_d = !launched;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign mask_clr = (state != ST_IDLE) && (nxt == ST_IDLE);

  sew_mask_acc #(.NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .clr(mask_clr), .add(mask_add),
    .idx(cmd_sector_idx), .mask(erase_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      launched    <= 1'b0;
      erase_start <= 1'b0;
    end else begin
      state       <= nxt;
      erase_start <= start_d;
      if (nxt == ST_IDLE) launched <= 1'b0;
      else if (start_d)   launched <= 1'b1;
    end
  end

  assign erase_active  = (state == ST_ERASE) || (state == ST_SWAIT);
  assign exec_hold     = (state == ST_SWAIT) || (state == ST_SUSP);
  assign suspended     = (state == ST_SUSP);
  assign window_closed = (state == ST_ERASE) || (state == ST_SWAIT) || (state == ST_SUSP);

  // R4: launch is a single-cycle pulse
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);
  // R4: window reads closed when the erase is launched
  p_start_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> window_closed && erase_active);
  // R6: mask frozen while the window stays closed
  p_mask_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    window_closed && $past(window_closed) |-> $stable(erase_mask));
  // R8: a suspended erase always has sectors queued
  p_susp_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> (erase_mask != '0));
  // R9: while suspended, only resume leaves the suspended state
  p_susp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    suspended && !cmd_resume |=> suspended);
  // R7: the executor is held whenever suspended
  p_hold_when_susp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> exec_hold && !erase_active);
endmodule

// File: tb/sim_sector_erase_ctl.sv
module sim_sector_erase_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 11;
  localparam int SW = 4;
  localparam int NV = 58;
  // op codes
  localparam logic [2:0] NOP = 3'd0, SEC = 3'd1, SUS = 3'd2, RES = 3'd3,
                         OTH = 3'd4, TCK = 3'd5, DON = 3'd6;
  // entry: {op, idx, expected mask, expected {active, suspended, closed, start, hold}}
  localparam logic [22:0] VEC [NV] = '{
    {SEC,4'd3,11'h008,5'b00000}, {TCK,4'd0,11'h008,5'b00000},
    {TCK,4'd0,11'h008,5'b00000}, {SEC,4'd0,11'h009,5'b00000},
    {TCK,4'd0,11'h009,5'b00000}, {TCK,4'd0,11'h009,5'b00000},
    {TCK,4'd0,11'h009,5'b00000}, {SEC,4'd10,11'h409,5'b00000},
    {TCK,4'd0,11'h409,5'b00000}, {TCK,4'd0,11'h409,5'b00000},
    {TCK,4'd0,11'h409,5'b00000}, {TCK,4'd0,11'h409,5'b10110},
    {NOP,4'd0,11'h409,5'b10100}, {SEC,4'd5,11'h409,5'b10100},
    {OTH,4'd0,11'h409,5'b10100}, {RES,4'd0,11'h409,5'b10100},
    {TCK,4'd0,11'h409,5'b10100}, {SUS,4'd0,11'h409,5'b10101},
    {SUS,4'd0,11'h409,5'b10101}, {TCK,4'd0,11'h409,5'b10101},
    {TCK,4'd0,11'h409,5'b01101}, {SEC,4'd2,11'h409,5'b01101},
    {OTH,4'd0,11'h409,5'b01101}, {SUS,4'd0,11'h409,5'b01101},
    {DON,4'd0,11'h409,5'b01101}, {RES,4'd0,11'h409,5'b10100},
    {RES,4'd0,11'h409,5'b10100}, {SUS,4'd0,11'h409,5'b10101},
    {TCK,4'd0,11'h409,5'b10101}, {TCK,4'd0,11'h409,5'b01101},
    {RES,4'd0,11'h409,5'b10100}, {DON,4'd0,11'h000,5'b00000},
    {DON,4'd0,11'h000,5'b00000}, {SUS,4'd0,11'h000,5'b00000},
    {RES,4'd0,11'h000,5'b00000}, {SEC,4'd7,11'h080,5'b00000},
    {TCK,4'd0,11'h080,5'b00000}, {OTH,4'd0,11'h000,5'b00000},
    {TCK,4'd0,11'h000,5'b00000}, {TCK,4'd0,11'h000,5'b00000},
    {TCK,4'd0,11'h000,5'b00000}, {TCK,4'd0,11'h000,5'b00000},
    {SEC,4'd1,11'h002,5'b00000}, {SUS,4'd0,11'h002,5'b01101},
    {SEC,4'd4,11'h002,5'b01101}, {TCK,4'd0,11'h002,5'b01101},
    {RES,4'd0,11'h002,5'b10110}, {NOP,4'd0,11'h002,5'b10100},
    {SUS,4'd0,11'h002,5'b10101}, {DON,4'd0,11'h000,5'b00000},
    {SEC,4'd11,11'h000,5'b00000}, {SEC,4'd6,11'h040,5'b00000},
    {SEC,4'd15,11'h040,5'b00000}, {TCK,4'd0,11'h040,5'b00000},
    {TCK,4'd0,11'h040,5'b00000}, {TCK,4'd0,11'h040,5'b00000},
    {TCK,4'd0,11'h040,5'b10110}, {DON,4'd0,11'h000,5'b00000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, cmd_sector = 0, cmd_suspend = 0, cmd_resume = 0, cmd_other = 0, erase_done = 0;
  logic [SW-1:0] cmd_sector_idx = '0;
  logic [NS-1:0] erase_mask;
  logic erase_start, erase_active, exec_hold, suspended, window_closed;
  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_erase_ctl #(.NUM_SECTORS(NS), .WINDOW_TICKS(4), .SUSPEND_TICKS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_sector(cmd_sector),
    .cmd_sector_idx(cmd_sector_idx), .cmd_suspend(cmd_suspend),
    .cmd_resume(cmd_resume), .cmd_other(cmd_other), .erase_done(erase_done),
    .erase_mask(erase_mask), .erase_start(erase_start), .erase_active(erase_active),
    .exec_hold(exec_hold), .suspended(suspended), .window_closed(window_closed)
  );

  function automatic logic [4:0] flags();
    return {erase_active, suspended, window_closed, erase_start, exec_hold};
  endfunction

  task automatic check(string req, logic [NS-1:0] em, logic [4:0] ef);
    tests++;
    if (erase_mask !== em || flags() !== ef) begin
      fails++;
      $display("FAIL %s: mask=%h flags=%b expected mask=%h flags=%b",
               req, erase_mask, flags(), em, ef);
    end
  endtask

  // drive one cycle of stimulus at negedge, sample at the next negedge
  task automatic step(logic [2:0] op, logic [SW-1:0] idx, logic tk);
    @(negedge clk);
    cmd_sector = (op == SEC); cmd_sector_idx = idx;
    cmd_suspend = (op == SUS); cmd_resume = (op == RES);
    cmd_other = (op == OTH); erase_done = (op == DON);
    tick = (op == TCK) || tk;
    @(negedge clk);
    {cmd_sector, cmd_suspend, cmd_resume, cmd_other, erase_done, tick} = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", '0, 5'b00000);
    rst_n = 1'b1;
    // vector walk: R2..R11 scenarios
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][22:20], VEC[i][19:16], 1'b0);
      check($sformatf("R2-R11 vector %0d", i), VEC[i][15:5], VEC[i][4:0]);
    end
    // R3: sector command coinciding with the expiring tick restarts the window
    step(SEC, 4'd2, 1'b0);
    for (int k = 0; k < 3; k++) step(TCK, '0, 1'b0);
    step(SEC, 4'd5, 1'b1);
    check("R3 restart on expiring tick", 11'h024, 5'b00000);
    for (int k = 0; k < 3; k++) step(TCK, '0, 1'b0);
    check("R3 window still open", 11'h024, 5'b00000);
    step(TCK, '0, 1'b0);
    check("R4 expire after restart", 11'h024, 5'b10110);
    step(DON, '0, 1'b0);
    check("R10 done", '0, 5'b00000);
    // R2/R3: all sectors queued in reverse order, then R5 discard
    for (int s = NS - 1; s >= 0; s--) step(SEC, SW'(s), 1'b0);
    check("R3 all sectors queued", 11'h7FF, 5'b00000);
    step(OTH, '0, 1'b0);
    check("R5 discard full mask", '0, 5'b00000);
    // R1: reset in the window clears everything
    step(SEC, 4'd9, 1'b0);
    check("R2 window open", 11'h200, 5'b00000);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset during window", '0, 5'b00000);
    rst_n = 1'b1;
    for (int k = 0; k < 5; k++) step(TCK, '0, 1'b0);
    check("R1 no erase after reset", '0, 5'b00000);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule